// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiply-Accumulator

This block multiplies two 8-bit two's-complement operands and adds the product to a running 16-bit total. A caller presents a multiplicand and a multiplier together with a valid strobe. The operands are registered on that clock edge. On the following edge the accumulated value reflects the new product. The total wraps modulo 2^16 and never saturates.

Inside, the registered multiplier is recoded into radix-4 Booth digits, which gives four 9-bit partial products. Each row's sign bit is replaced by its inverse, and a single constant word compensates for every row at once, so no row needs sign extension. The rows, the negation carry-ins, the compensation constant and the current total all enter one carry-save tree. A carry-lookahead adder then resolves the tree's two output vectors into the next total. The sign fixes are derived combinationally from the registered operands, so they always act in the same cycle as their own partial products.

Top module: `booth_mac`

## Requirements
- R1: When `rst` is high at a clock edge, the accumulator and the operand stage are cleared, so `acc_out` reads 0 afterwards and the first cycle after reset adds nothing.
- R2: Operands presented with `in_valid` high are captured on one rising edge. The total that includes their product appears on `acc_out` after the next rising edge, not earlier.
- R3: When `in_valid` is low, the operands are ignored and `acc_out` keeps its value on every following edge.
- R4: Each accepted operand pair adds the signed product mcand*mplier to the total, modulo 2^16.
- R5: Booth digit i is taken from multiplier bits (2i+1, 2i, 2i-1), with bit -1 treated as 0. It selects 0, +M, +2M, -M or -2M, and every multiplier bit pattern yields the exact product.
- R6: Negative digits are formed by inverting the row and adding a carry-in at that row's lowest position. The extreme -128 * -128 gives +16384.
- R7: Each row carries the inverse of its sign bit, and one constant word (0xAB00 for 8-bit operands) compensates for all rows. Products with negative results are therefore exact.
- R8: Starting from reset, accepting 10*19 gives 190, and then accepting 11*13 gives 333.
- R9: The total wraps in two's complement. Two products of 16384 give 0x8000, and four give 0x0000.
- R10: With `in_valid` high on consecutive edges, every pair is accumulated, one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on this edge are to be accumulated |
| mcand | input | 8 | Signed multiplicand |
| mplier | input | 8 | Signed multiplier |
| acc_out | output | 16 | Registered accumulated total |

## Verification
A pair offered on one edge is first visible on `acc_out` two rising edges later: one edge registers the operands and the next loads the total. The bench drives inputs on falling edges and reads the output on falling edges. After the first edge it confirms that the total has not yet moved, and after the second edge it compares the total with its own running model. For streams of back-to-back pairs, each falling edge shows the sum of all pairs offered two or more edges earlier. The bench checks both the partial total and the final total.

// File: rtl/booth_mac_pkg.sv
package booth_mac_pkg;

  // Sum of the hidden sign weights of every Booth row, negated modulo 2^64.
  // Row i places its inverted sign at weight 2^(w + 2i); this constant cancels them.
  function automatic longint unsigned sign_comp(input int w, input int rows);
    longint unsigned total;
    total = 0;
    for (int i = 0; i < rows; i++) begin
      total = total + (longint'(1) << (w + 2 * i));
    end
    return (~total) + 1;
  endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder #(
  parameter int W    = 8,
  parameter int ROWS = W / 2
) (
  input  logic [W-1:0]           mcand,
  input  logic [W-1:0]           mplier,
  output logic [ROWS-1:0][W:0]   pp,
  output logic [ROWS-1:0]        neg
);

  // multiplier with an implicit zero below bit 0
  logic [W:0] ext;
  assign ext = {mplier, 1'b0};

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    logic b_hi, b_mid, b_lo;
    logic sel_one, sel_two;
    logic [W:0] raw;

    assign b_lo  = ext[2*i];
    assign b_mid = ext[2*i+1];
    assign b_hi  = ext[2*i+2];

    assign sel_one = b_mid ^ b_lo;
    assign sel_two = (b_hi & ~b_mid & ~b_lo) | (~b_hi & b_mid & b_lo);

    always_comb begin
      if (sel_one)      raw = {mcand[W-1], mcand};
      else if (sel_two) raw = {mcand, 1'b0};
      else              raw = '0;
    end

    assign pp[i]  = raw ^ {(W+1){b_hi}};
    assign neg[i] = b_hi;

    // R5
    always_comb begin
      digit_sel_chk: assert ($onehot0({sel_one, sel_two}))
        else $error("booth digit selects both M and 2M");
    end
  end

endmodule

// File: rtl/booth_csa_tree.sv
module booth_csa_tree #(
  parameter int W     = 16,
  parameter int NTERM = 6
) (
  input  logic [NTERM-1:0][W-1:0] terms,
  output logic [W-1:0]            sum_vec,
  output logic [W-1:0]            carry_vec
);

  localparam int NSTAGE = NTERM - 2;

  logic [NSTAGE:0][W-1:0] s_ch;
  logic [NSTAGE:0][W-1:0] c_ch;

  assign s_ch[0] = terms[0];
  assign c_ch[0] = terms[1];

  for (genvar k = 0; k < NSTAGE; k++) begin : g_csa
    logic [W-1:0] x, y, z, maj;
    assign x   = s_ch[k];
    assign y   = c_ch[k];
    assign z   = terms[k+2];
    assign maj = (x & y) | (x & z) | (y & z);
    assign s_ch[k+1] = x ^ y ^ z;
    assign c_ch[k+1] = {maj[W-2:0], 1'b0};
  end

  assign sum_vec   = s_ch[NSTAGE];
  assign carry_vec = c_ch[NSTAGE];

endmodule

// File: rtl/booth_cla.sv
module booth_cla #(
  parameter int W = 16,
  parameter int G = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);

  localparam int NG = W / G;

  logic [W-1:0] gen, prp;
  logic [NG:0]  gc;

  assign gen   = a & b;
  assign prp   = a ^ b;
  assign gc[0] = 1'b0;

  for (genvar grp = 0; grp < NG; grp++) begin : g_grp
    localparam int BASE = grp * G;
    logic [G:0] cl;

    // each carry expanded in lookahead form from the group carry-in
    always_comb begin
      logic run_v;
      logic acc_v;
      for (int k = 0; k <= G; k++) begin
        acc_v = 1'b0;
        run_v = 1'b1;
        for (int j = k - 1; j >= 0; j--) begin
          acc_v = acc_v | (run_v & gen[BASE + j]);
          run_v = run_v & prp[BASE + j];
        end
        cl[k] = acc_v | (run_v & gc[grp]);
      end
    end

    assign sum[BASE +: G] = prp[BASE +: G] ^ cl[G-1:0];
    assign gc[grp+1]      = cl[G];
  end

  // R4
  always_comb begin
    cla_sum_chk: assert (sum == W'(a + b))
      else $error("lookahead sum disagrees with a+b");
  end

endmodule

// File: rtl/booth_mac.sv
module booth_mac #(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [W-1:0]     mcand,
  input  logic [W-1:0]     mplier,
  output logic [2*W-1:0]   acc_out
);
  import booth_mac_pkg::*;

  localparam int ROWS  = W / 2;
  localparam int ACCW  = 2 * W;
  localparam int NTERM = ROWS + 2;
  localparam longint unsigned COMP_FULL = sign_comp(W, ROWS);
  localparam logic [ACCW-1:0] COMP = COMP_FULL[ACCW-1:0];

  logic [W-1:0]    a_q, b_q;
  logic            vld_q;
  logic [ACCW-1:0] acc_q;

  // stage 1: operand capture
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      b_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        a_q <= mcand;
        b_q <= mplier;
      end
    end
  end

  // Booth rows from the registered operands (no extra register on sign fixes)
  logic [ROWS-1:0][W:0] pp;
  logic [ROWS-1:0]      neg;

  booth_recoder #(.W(W), .ROWS(ROWS)) u_rec (
    .mcand (a_q),
    .mplier(b_q),
    .pp    (pp),
    .neg   (neg)
  );

  logic [NTERM-1:0][ACCW-1:0] terms;
  logic [ACCW-1:0]            fix_term;

  always_comb begin
    fix_term = COMP;
    for (int i = 0; i < ROWS; i++) begin
      fix_term[2*i] = neg[i];
    end
  end

  for (genvar i = 0; i < ROWS; i++) begin : g_place
    logic [ACCW-1:0] row_w;
    assign row_w    = ACCW'({~pp[i][W], pp[i][W-1:0]});
    assign terms[i] = row_w << (2 * i);
  end

  assign terms[ROWS]   = fix_term;
  assign terms[ROWS+1] = acc_q;

  logic [ACCW-1:0] sv, cv, next_acc;

  booth_csa_tree #(.W(ACCW), .NTERM(NTERM)) u_tree (
    .terms    (terms),
    .sum_vec  (sv),
    .carry_vec(cv)
  );

  booth_cla #(.W(ACCW), .G(4)) u_cla (
    .a  (sv),
    .b  (cv),
    .sum(next_acc)
  );

  // stage 2: accumulate
  always_ff @(posedge clk) begin
    if (rst)        acc_q <= '0;
    else if (vld_q) acc_q <= next_acc;
  end

  assign acc_out = acc_q;

  // behavioural product used only by the checks below
  logic [ACCW-1:0] ref_sum;
  assign ref_sum = acc_q + ACCW'($signed(ACCW'($signed(a_q))) * $signed(ACCW'($signed(b_q))));

  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> (acc_q == '0) && !vld_q)
    else $error("reset did not clear state");

  // R2
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> vld_q && (a_q == $past(mcand)) && (b_q == $past(mplier)))
    else $error("operands not captured");

  // R3
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_q |=> $stable(acc_q))
    else $error("accumulator moved without valid operands");

  // R4
  product_sum_chk: assert property (@(posedge clk) disable iff (rst)
    vld_q |=> acc_q == $past(ref_sum))
    else $error("carry-save result differs from signed product sum");

endmodule

// File: tb/booth_mac_tb_top.sv
module booth_mac_tb_top;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [7:0]  mcand, mplier;
  logic [15:0] acc_out;

  int n_chk  = 0;
  int n_fail = 0;
  logic [15:0] model = '0;

  always #(CLK_P/2) clk = ~clk;

  booth_mac #(.W(8)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .mcand   (mcand),
    .mplier  (mplier),
    .acc_out (acc_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: acc_out=0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] prod(input logic [7:0] a, input logic [7:0] b);
    int p;
    p = int'($signed(a)) * int'($signed(b));
    return p[15:0];
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; mcand = 8'd55; mplier = 8'd66;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    model = '0;
    @(negedge clk);
    // R1: cleared, and nothing added after release
    chk("R1", acc_out, 16'h0000);
  endtask

  // one pair, checking the latency of R2 on the way
  task automatic mac_one(input string req, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    in_valid = 1'b0; mcand = ~a; mplier = ~b;
    chk("R2", acc_out, model);
    model = model + prod(a, b);
    @(negedge clk);
    chk(req, acc_out, model);
  endtask

  task automatic t_example();
    do_reset();
    mac_one("R8", 8'd10, 8'd19);
    chk("R8", acc_out, 16'd190);
    mac_one("R8", 8'd11, 8'd13);
    chk("R8", acc_out, 16'd333);
  endtask

  task automatic t_hold();
    logic [15:0] held;
    held = acc_out;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b0; mcand = 8'(k * 37 + 5); mplier = 8'(k * 91 + 3);
      @(negedge clk);
      chk("R3", acc_out, held);
    end
  endtask

  task automatic t_sweep();
    logic [7:0] as [5] = '{8'h80, 8'h7F, 8'hFF, 8'h05, 8'hC3};
    do_reset();
    for (int i = 0; i < 5; i++) begin
      for (int b = 0; b < 256; b += 17) begin
        mac_one("R5", as[i], 8'(b));
      end
    end
    do_reset();
    mac_one("R6", 8'h80, 8'h80);
    chk("R6", acc_out, 16'd16384);
    do_reset();
    mac_one("R7", 8'd100, 8'hF6);
    chk("R7", acc_out, 16'hFC18);
    mac_one("R7", 8'h81, 8'h7F);
    mac_one("R4", 8'h9C, 8'h9C);
  endtask

  task automatic t_stream();
    logic [7:0] sa [4] = '{8'd3, 8'hF0, 8'd127, 8'h80};
    logic [7:0] sb [4] = '{8'd7, 8'd9, 8'hAA, 8'h01};
    logic [15:0] part;
    do_reset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1'b1; mcand = sa[i]; mplier = sb[i];
    end
    @(negedge clk);
    in_valid = 1'b0;
    part = prod(sa[0], sb[0]) + prod(sa[1], sb[1]) + prod(sa[2], sb[2]);
    chk("R10", acc_out, part);
    @(negedge clk);
    model = part + prod(sa[3], sb[3]);
    chk("R10", acc_out, model);
  endtask

  task automatic t_wrap();
    do_reset();
    mac_one("R9", 8'h80, 8'h80);
    mac_one("R9", 8'h80, 8'h80);
    chk("R9", acc_out, 16'h8000);
    mac_one("R9", 8'h80, 8'h80);
    mac_one("R9", 8'h80, 8'h80);
    chk("R9", acc_out, 16'h0000);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: acc_out=0x%04h expected completion", acc_out);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; mcand = '0; mplier = '0;
    @(negedge clk);
    @(negedge clk);
    chk("R1", acc_out, 16'h0000);
    t_example();
    t_hold();
    t_sweep();
    t_stream();
    t_hold();
    t_wrap();
    do_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule